// File: doc/BRIEF.md
# Continuously Variable Slope Delta Codec

This block is a fully digital slope-adaptive delta modulator. In encode mode it compares a signed PCM sample with its own running estimate and produces one serial bit per bit clock. In decode mode it rebuilds the same estimate from a received bit stream. Both directions share one adaptive path. A syllabic filter sets the step size from runs of equal bits. A leaky integrator forms the estimate, which is presented on `pcm_out` as the reconstructed signal.

Three extra behaviours sit on top of plain slope-adaptive delta modulation. A force-quiet input replaces the bit stream with an alternating idle pattern. An active-low level flag reports when the estimate reaches half of full scale. A clamp stops integration when the estimate reaches three quarters of full scale. All state advances on the rising clock edge. The serial output is retimed onto the falling edge, so it changes half a period after the decision.

Top module: `cvsd_codec`

## Requirements
- R1: While `rst_n` is low, `pcm_out` is 0, `dout` is 0 and `agc_n` is 1. Reset clears the estimate, the step filter and the two-bit history (history bits are 0).
- R2: With `enc_mode`=1 and `force_quiet`=0, the bit taken at a rising edge is 1 when the signed `pcm_in` is greater than or equal to the estimate, and 0 otherwise.
- R3: `dout` changes only on falling edges. After each falling edge it carries the bit decided at the preceding rising edge.
- R4: With `enc_mode`=0 and `force_quiet`=0, the bit taken is `din` as sampled on the rising edge, and `pcm_in` has no effect.
- R5: When the estimate E satisfies |E| < 3/4 of full scale (1536 for 12 bits), the next estimate is R - floor(R/16), where R = E+step for bit 1 and R = E-step for bit 0. The result is limited to ±1536.
- R6: When |E| >= 1536, the bit is ignored and the next estimate is E - floor(E/16). The clamp releases once the magnitude falls below 1536.
- R7: The step is STEP_MIN + floor(S/64), with STEP_MIN=2 by default. The filter state S is updated as S - floor(S/64), plus 254 when the current bit equals both of the two previous bits. The step used at an edge is the one held before that edge, and it always lies in [2, 256].
- R8: With `force_quiet`=1, the bit taken is the inverse of the previous bit, whatever the mode, `din` and `pcm_in`. `dout` therefore toggles on every falling edge.
- R9: `agc_n` is 0 exactly when the magnitude of `pcm_out` is at least half of full scale (1024), for either polarity.
- R10: `enc_mode` can change on any cycle. Each rising edge uses the source selected at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; state on rising edge, serial output on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_mode | input | 1 | 1 = encode from `pcm_in`, 0 = decode from `din` |
| force_quiet | input | 1 | Forces the alternating idle bit pattern |
| din | input | 1 | Received serial bit (decode) |
| pcm_in | input | PCM_W | Signed PCM sample to encode |
| dout | output | 1 | Serial bit stream, falling-edge timed |
| pcm_out | output | PCM_W | Signed reconstructed estimate |
| agc_n | output | 1 | Low when the estimate magnitude is at or above half scale |

## Verification
The bench changes inputs 2 ns after a falling edge. Within the same call it advances a reference model by one step, computed with floor division rather than shifts. `pcm_out` and `agc_n` are due one rising edge after the inputs. `dout` is due half a period later, at the next falling edge, and all three are compared 2 ns after that edge. To cover R3, `dout` is also read 1 ns after the rising edge and must still hold its earlier value. The sweeps cover triangle inputs of several amplitudes up to full scale, so the clamp is reached. They also cover fixed and pseudo-random decode streams, quiet mode in both modes, per-cycle mode switching and a reset in mid-run.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;

  // arithmetic right shift of a signed value: floor division by 2**sh
  function automatic int floor_shift(input int v, input int sh);
    return v >>> sh;
  endfunction

  // single-pole leak: remove 1/2**sh of the value
  function automatic int leak(input int v, input int sh);
    return v - floor_shift(v, sh);
  endfunction

  function automatic int magnitude(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int limit(input int v, input int lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  // next estimate: clamp freezes integration, otherwise step, leak, limit
  function automatic int integrate(input int e, input logic up, input int step,
                                   input int sh, input int clamp_lvl);
    int raw;
    if (magnitude(e) >= clamp_lvl) return leak(e, sh);
    raw = up ? (e + step) : (e - step);
    return limit(leak(raw, sh), clamp_lvl);
  endfunction

  // syllabic filter: decay toward zero, charge by span on overload
  function automatic int syllabic(input int s, input logic ovl, input int sh,
                                  input int span);
    return s - floor_shift(s, sh) + (ovl ? span : 0);
  endfunction

endpackage

// File: rtl/cvsd_bit_source.sv
module cvsd_bit_source #(
  parameter int PCM_W   = 12,
  parameter int OVL_RUN = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enc_mode,
  input  logic                    force_quiet,
  input  logic                    din,
  input  logic signed [PCM_W-1:0] pcm_in,
  input  logic signed [PCM_W-1:0] est,
  output logic                    bit_now,
  output logic                    cur_bit,
  output logic                    ovl
);
  localparam int HIST_W = OVL_RUN - 1;

  logic [HIST_W-1:0] hist_q;
  logic              cmp_bit;

  assign cmp_bit = (pcm_in >= est);
  assign cur_bit = hist_q[0];

  always_comb begin
    if (force_quiet)   bit_now = ~hist_q[0];
    else if (enc_mode) bit_now = cmp_bit;
    else               bit_now = din;
  end

  always_comb begin
    ovl = 1'b1;
    for (int i = 0; i < HIST_W; i++) begin
      if (hist_q[i] != bit_now) ovl = 1'b0;
    end
  end

  generate
    if (HIST_W == 1) begin : g_hist1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= bit_now;
      end
    end else begin : g_histn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[HIST_W-2:0], bit_now};
      end
    end
  endgenerate

  // R8
  quiet_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_quiet |=> (cur_bit != $past(cur_bit)));

  // R4
  decode_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enc_mode && !force_quiet) |=> (cur_bit == $past(din)));

endmodule

// File: rtl/cvsd_syllabic.sv
module cvsd_syllabic #(
  parameter int STEP_W    = 9,
  parameter int SYL_SHIFT = 6,
  parameter int STEP_MIN  = 2,
  parameter int STEP_MAX  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovl,
  output logic [STEP_W-1:0] step
);
  localparam int SYL_W     = STEP_W + SYL_SHIFT;
  localparam int STEP_SPAN = STEP_MAX - STEP_MIN;

  logic [SYL_W-1:0] syl_q;
  int               syl_i;

  assign syl_i = int'(syl_q);
  assign step  = STEP_W'(STEP_MIN + cvsd_pkg::floor_shift(syl_i, SYL_SHIFT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syl_q <= '0;
    else        syl_q <= SYL_W'(cvsd_pkg::syllabic(syl_i, ovl, SYL_SHIFT, STEP_SPAN));
  end

  // R7
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(step) >= STEP_MIN) && (int'(step) <= STEP_MAX));

endmodule

// File: rtl/cvsd_integrator.sv
module cvsd_integrator #(
  parameter int PCM_W     = 12,
  parameter int STEP_W    = 9,
  parameter int EST_SHIFT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_now,
  input  logic [STEP_W-1:0]       step,
  output logic signed [PCM_W-1:0] est,
  output logic                    agc_n
);
  localparam int CLAMP_LVL = 3 * (2 ** (PCM_W - 3));
  localparam int HALF_LVL  = 2 ** (PCM_W - 2);

  logic signed [PCM_W-1:0] est_q;
  int                      est_i;
  int                      est_abs;
  logic                    clamped;

  assign est_i   = int'(est_q);
  assign est_abs = cvsd_pkg::magnitude(est_i);
  assign clamped = (est_abs >= CLAMP_LVL);
  assign agc_n   = (est_abs < HALF_LVL);
  assign est     = est_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) est_q <= '0;
    else est_q <= PCM_W'(cvsd_pkg::integrate(est_i, bit_now, int'(step),
                                             EST_SHIFT, CLAMP_LVL));
  end

  // R5
  est_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    est_abs <= CLAMP_LVL);

  // R6
  clamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamped |=> (est_abs <= $past(est_abs)));

endmodule

// File: rtl/cvsd_codec.sv
module cvsd_codec #(
  parameter int PCM_W     = 12,
  parameter int STEP_W    = 9,
  parameter int STEP_MIN  = 2,
  parameter int STEP_MAX  = 256,
  parameter int SYL_SHIFT = 6,
  parameter int EST_SHIFT = 4,
  parameter int OVL_RUN   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enc_mode,
  input  logic                    force_quiet,
  input  logic                    din,
  input  logic signed [PCM_W-1:0] pcm_in,
  output logic                    dout,
  output logic signed [PCM_W-1:0] pcm_out,
  output logic                    agc_n
);
  logic                    bit_now;
  logic                    cur_bit;
  logic                    ovl;
  logic [STEP_W-1:0]       step;
  logic signed [PCM_W-1:0] est;
  logic                    dout_q;

  cvsd_bit_source #(.PCM_W(PCM_W), .OVL_RUN(OVL_RUN)) u_src (
    .clk(clk), .rst_n(rst_n), .enc_mode(enc_mode), .force_quiet(force_quiet),
    .din(din), .pcm_in(pcm_in), .est(est), .bit_now(bit_now),
    .cur_bit(cur_bit), .ovl(ovl));

  cvsd_syllabic #(.STEP_W(STEP_W), .SYL_SHIFT(SYL_SHIFT), .STEP_MIN(STEP_MIN),
                  .STEP_MAX(STEP_MAX)) u_syl (
    .clk(clk), .rst_n(rst_n), .ovl(ovl), .step(step));

  cvsd_integrator #(.PCM_W(PCM_W), .STEP_W(STEP_W), .EST_SHIFT(EST_SHIFT)) u_int (
    .clk(clk), .rst_n(rst_n), .bit_now(bit_now), .step(step), .est(est),
    .agc_n(agc_n));

  // serial output retimed onto the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= 1'b0;
    else        dout_q <= cur_bit;
  end

  assign dout    = dout_q;
  assign pcm_out = est;

  // R3
  dout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout == cur_bit);

endmodule

// File: tb/cvsd_codec_tb.sv
`timescale 1ns/1ps
module cvsd_codec_tb;
  localparam int W     = 12;
  localparam int SMIN  = 2;
  localparam int SPAN  = 254;
  localparam int CLAMP = 1536;
  localparam int HALF  = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_mode = 1'b0;
  logic force_quiet = 1'b0;
  logic din = 1'b0;
  logic signed [W-1:0] pcm_in = '0;
  logic dout;
  logic signed [W-1:0] pcm_out;
  logic agc_n;

  int checks = 0;
  int errors = 0;
  int m_est = 0;
  int m_syl = 0;
  logic m_h0 = 1'b0;
  logic m_h1 = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  cvsd_codec u_dut (
    .clk(clk), .rst_n(rst_n), .enc_mode(enc_mode), .force_quiet(force_quiet),
    .din(din), .pcm_in(pcm_in), .dout(dout), .pcm_out(pcm_out), .agc_n(agc_n));

  function automatic int fdiv(input int v, input int d);
    if (v < 0 && (v % d) != 0) return v / d - 1;
    return v / d;
  endfunction

  function automatic int absv(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // one bit period: drive, model, wait, compare
  task automatic run_cycle(input logic enc, input logic q, input logic d,
                           input int pcm, input string mtag);
    logic b, ovl, dprev, was_clamped;
    int stp, raw, nxt;
    enc_mode = enc; force_quiet = q; din = d; pcm_in = W'(pcm);
    if (q) b = ~m_h0;
    else if (enc) b = (pcm >= m_est);
    else b = d;
    ovl = (b == m_h0) && (b == m_h1);
    stp = SMIN + m_syl / 64;
    was_clamped = (absv(m_est) >= CLAMP);
    if (was_clamped) nxt = m_est - fdiv(m_est, 16);
    else begin
      raw = b ? m_est + stp : m_est - stp;
      nxt = raw - fdiv(raw, 16);
      if (nxt > CLAMP) nxt = CLAMP;
      if (nxt < -CLAMP) nxt = -CLAMP;
    end
    m_syl = m_syl - m_syl / 64 + (ovl ? SPAN : 0);
    m_est = nxt; m_h1 = m_h0; m_h0 = b;
    dprev = dout;
    @(posedge clk); #1;
    check(dout == dprev, "R3 dout moved on rising edge", dout, dprev);
    @(negedge clk); #2;
    check(int'(pcm_out) == m_est, was_clamped ? "R6 clamp" : "R5 R7 estimate",
          int'(pcm_out), m_est);
    check(dout == b, q ? "R8 quiet bit" : (enc ? {"R2 encode ", mtag} : {"R4 decode ", mtag}),
          dout, b);
    check(agc_n == (absv(m_est) < HALF), "R9 level flag", agc_n, absv(m_est) < HALF);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check(int'(pcm_out) == 0, "R1 reset pcm_out", int'(pcm_out), 0);
    check(dout == 1'b0, "R1 reset dout", dout, 0);
    check(agc_n == 1'b1, "R1 reset agc_n", agc_n, 1);
    m_est = 0; m_syl = 0; m_h0 = 1'b0; m_h1 = 1'b0;
    rst_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int amps[5] = '{0, 120, 700, 1600, 2047};
    int pers[3] = '{4, 16, 64};
    @(negedge clk); #2;
    do_reset();
    // R2: triangle sweeps over amplitude and period
    foreach (amps[a]) begin
      foreach (pers[p]) begin
        for (int n = 0; n < 4 * pers[p] + 40; n++) begin
          int ph, v;
          ph = n % (2 * pers[p]);
          v = (ph < pers[p]) ? ph : 2 * pers[p] - ph;
          run_cycle(1'b1, 1'b0, lfsr[0], -amps[a] + (2 * amps[a] * v) / pers[p], "tri");
          next_rand();
        end
      end
    end
    // R2 R6: full-scale steps drive the clamp both ways
    for (int n = 0; n < 120; n++) run_cycle(1'b1, 1'b0, 1'b0, 2047, "hi");
    for (int n = 0; n < 120; n++) run_cycle(1'b1, 1'b0, 1'b1, -2048, "lo");
    // R4: fixed and pseudo-random streams, pcm_in scrambled
    for (int n = 0; n < 150; n++) run_cycle(1'b0, 1'b0, 1'b1, int'($signed(lfsr[11:0])), "ones");
    for (int n = 0; n < 150; n++) run_cycle(1'b0, 1'b0, 1'b0, 999, "zeros");
    for (int n = 0; n < 100; n++) run_cycle(1'b0, 1'b0, n[0], -5, "alt");
    for (int n = 0; n < 600; n++) begin
      run_cycle(1'b0, 1'b0, lfsr[3], int'($signed(lfsr[15:4])), "rand");
      next_rand();
    end
    // R8: quiet in both modes with busy inputs
    for (int n = 0; n < 200; n++) begin
      run_cycle(lfsr[1], 1'b1, lfsr[2], int'($signed(lfsr[11:0])), "quiet");
      next_rand();
    end
    // R10: mode switches every cycle
    for (int n = 0; n < 600; n++) begin
      run_cycle(lfsr[5], 1'b0, lfsr[7], int'($signed(lfsr[15:4])), "R10 switch");
      next_rand();
    end
    // R1: reset in mid-run, then resume
    for (int n = 0; n < 30; n++) run_cycle(1'b0, 1'b0, 1'b1, 0, "pre");
    do_reset();
    for (int n = 0; n < 60; n++) run_cycle(1'b1, 1'b0, 1'b0, 300, "post");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule